// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block connects a simple synchronous host port to one asynchronous 4M x 4 DRAM with extended data output. A host request carries a 22-bit word address, a write flag and a 4-bit write value, and it is accepted on a valid/ready handshake. The controller splits the address into a 12-bit row and a 10-bit column and drives them one after the other on the shared address pins. It strobes the row and column lines and returns read data with a one-cycle valid pulse. After an access it leaves the row open, so that later requests to the same row need only a column strobe. Refresh is scheduled internally with cycles in which the column strobe falls before the row strobe.

The controller is one state machine. Its states are: `ST_PWRUP` (power-up wait), `ST_IDLE` (no row open), `ST_ACT` (row strobe low, row address driven), `ST_COL` (column address and write controls set up), `ST_CAS` (column strobe low), `ST_CASH` (column strobe high, read data captured), `ST_OPEN` (row held open and waiting), `ST_PRE` (row closed, precharge), and the refresh states `ST_RCAS` (column strobe first), `ST_RRAS` (both strobes low) and `ST_RPRE` (refresh precharge). The transitions are:
- `PWRUP->IDLE` when the delay expires.
- `IDLE->RCAS` when a refresh is due and the row-cycle guard is clear.
- `IDLE->ACT` for a held or a new request.
- `ACT->COL` after T_RCD clocks.
- `COL->CAS`.
- `CAS->CASH` after T_CAS clocks.
- `CASH->OPEN`.
- `CASH/OPEN->COL` on a page hit.
- `CASH/OPEN->PRE` on a page miss, a pending refresh, or (from OPEN) the idle timeout.
- `PRE->IDLE`.
- `RCAS->RRAS`.
- `RRAS->RPRE`.
- `RPRE->IDLE`.

Top module: `edo_dram_ctrl`

## Requirements
- R1: While reset is held and after it, `dram_ras_n`, `dram_cas_n`, `dram_we_n` and `dram_oe_n` are high, `dram_dq_oe` and `req_ready` are low, and no row strobe falls for PWRUP_CYC clocks after reset is released.
- R2: After the power-up delay, exactly INIT_REF (default 8) refresh cycles run before `req_ready` first goes high.
- R3: The row is `req_addr[21:10]` and is on `dram_addr` when the row strobe falls. The column is `req_addr[9:0]`, zero-extended, and is on `dram_addr` when the column strobe falls.
- R4: A request whose row equals the open row is served with a column strobe only, with no new row strobe.
- R5: Before every fall of the row strobe, the row strobe has been high for at least T_RP clocks. A page miss closes the open row first.
- R6: Two falls of the row strobe are at least T_RC clocks apart (default 9).
- R7: For a read, data is captured on the edge at which the column strobe rises. This edge is at least 5 clocks after the row strobe fell and at least 3 clocks after the column address was driven. `rd_valid` is a one-cycle pulse in the cycle after that edge, and read results come back in request order.
- R8: During a write, `dram_we_n` is low and `dram_dq_oe` is high, with `dram_dq_out` carrying the data, from one clock before the column strobe falls. `dram_oe_n` stays high whenever `dram_we_n` is low.
- R9: A refresh lowers the column strobe at least one clock before the row strobe. Refreshes are requested every REFI_CYC clocks and keep occurring while the host is idle.
- R10: While a refresh is pending, `req_ready` is low. An open row is closed before the refresh starts, so refreshes still occur under a continuous stream of page hits.
- R11: With a row open and no request, the row strobe rises after IDLE_CLOSE clocks.
- R12: A request is taken only on a clock where `req_valid` and `req_ready` are both high, and every accepted read yields exactly one `rd_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | 22 | Word address, row in upper 12 bits, column in lower 10 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 4 | Read data |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_in | input | 4 | Data from the DRAM pins |
| dram_dq_out | output | 4 | Data toward the DRAM pins |
| dram_dq_oe | output | 1 | Drive enable for the data pins |

## Verification
The bench keeps the default row, column and timing parameters. It shortens PWRUP_CYC to 40, REFI_CYC to 400 and IDLE_CLOSE to 20. With these values the power-up sequence, the idle row closure and several periodic refreshes all occur within a few thousand clocks. A behavioural DRAM model in the bench returns inverted data for any read sampled before the access limits are met, and it measures row-cycle and precharge gaps on its own. The run also holds a long stream of page hits long enough for a refresh to interrupt it.

// File: rtl/edo_pkg.sv
package edo_pkg;
    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_ACT,
        ST_COL,
        ST_CAS,
        ST_CASH,
        ST_OPEN,
        ST_PRE,
        ST_RCAS,
        ST_RRAS,
        ST_RPRE
    } edo_state_e;
endpackage

// File: rtl/edo_refresh_timer.sv
// Raises a refresh request every REFI_CYC clocks; cleared by ack_i.
module edo_refresh_timer #(
    parameter int REFI_CYC = 1562
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_i,
    output logic pend_o
);
    localparam int TW = $clog2(REFI_CYC + 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= TW'(REFI_CYC - 1);
            pend_o <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q  <= TW'(REFI_CYC - 1);
            pend_o <= 1'b1;
        end else begin
            cnt_q <= cnt_q - 1'b1;
            if (ack_i) pend_o <= 1'b0;
        end
    end
endmodule

// File: rtl/edo_ras_guard.sv
// Counts the row cycle time from each row strobe fall.
module edo_ras_guard #(
    parameter int T_RC = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic clear_o
);
    localparam int GW = $clog2(T_RC + 1);

    logic [GW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start_i)        cnt_q <= GW'(T_RC - 1);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign clear_o = (cnt_q == '0);
endmodule

// File: rtl/edo_row_track.sv
// Remembers the open row and compares an incoming row against it.
module edo_row_track #(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_i,
    input  logic             close_i,
    input  logic [ROW_W-1:0] row_i,
    input  logic [ROW_W-1:0] cmp_row_i,
    output logic             hit_o
);
    logic             valid_q;
    logic [ROW_W-1:0] row_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            row_q   <= '0;
        end else if (open_i) begin
            valid_q <= 1'b1;
            row_q   <= row_i;
        end else if (close_i) begin
            valid_q <= 1'b0;
        end
    end

    assign hit_o = valid_q && (row_q == cmp_row_i);
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
    import edo_pkg::*;
#(
    parameter int ROW_W      = 12,
    parameter int COL_W      = 10,
    parameter int DQ_W       = 4,
    parameter int PWRUP_CYC  = 20000,
    parameter int REFI_CYC   = 1562,
    parameter int INIT_REF   = 8,
    parameter int T_RC       = 9,
    parameter int T_RP       = 3,
    parameter int T_RCD      = 2,
    parameter int T_CAS      = 2,
    parameter int T_RAS      = 5,
    parameter int IDLE_CLOSE = 64
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    req_valid,
    output logic                                    req_ready,
    input  logic [ROW_W+COL_W-1:0]                  req_addr,
    input  logic                                    req_we,
    input  logic [DQ_W-1:0]                         req_wdata,
    output logic                                    rd_valid,
    output logic [DQ_W-1:0]                         rd_data,
    output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0]  dram_addr,
    output logic                                    dram_ras_n,
    output logic                                    dram_cas_n,
    output logic                                    dram_we_n,
    output logic                                    dram_oe_n,
    input  logic [DQ_W-1:0]                         dram_dq_in,
    output logic [DQ_W-1:0]                         dram_dq_out,
    output logic                                    dram_dq_oe
);
    localparam int ADDR_W  = ROW_W + COL_W;
    localparam int BUS_W   = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int CNT_MAX = (PWRUP_CYC > IDLE_CLOSE) ? PWRUP_CYC : IDLE_CLOSE;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int INIT_W  = $clog2(INIT_REF + 1);

    edo_state_e        state_q, state_d;
    logic [CNT_W-1:0]  wcnt_q;
    logic [INIT_W-1:0] init_left_q;
    logic [ROW_W-1:0]  lat_row_q;
    logic [COL_W-1:0]  lat_col_q;
    logic              lat_we_q;
    logic [DQ_W-1:0]   lat_wd_q;
    logic              have_req_q;
    logic              rd_valid_q;
    logic [DQ_W-1:0]   rd_data_q;

    logic ref_pend, rc_clear, row_hit;
    logic accept, ref_go, wdone, ras_start;

    function automatic logic [CNT_W-1:0] dur(edo_state_e s);
        unique case (s)
            ST_PWRUP:        dur = CNT_W'(PWRUP_CYC - 1);
            ST_ACT:          dur = CNT_W'(T_RCD - 1);
            ST_CAS:          dur = CNT_W'(T_CAS - 1);
            ST_RRAS:         dur = CNT_W'(T_RAS - 1);
            ST_PRE, ST_RPRE: dur = CNT_W'(T_RP - 1);
            ST_OPEN:         dur = CNT_W'(IDLE_CLOSE - 1);
            default:         dur = '0;
        endcase
    endfunction

    assign accept    = req_valid && req_ready;
    assign ref_go    = ref_pend || (init_left_q != '0);
    assign wdone     = (wcnt_q == '0);
    assign ras_start = (state_d != state_q) && ((state_d == ST_ACT) || (state_d == ST_RRAS));

    edo_refresh_timer #(.REFI_CYC(REFI_CYC)) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack_i  (state_q == ST_RCAS),
        .pend_o (ref_pend)
    );

    edo_ras_guard #(.T_RC(T_RC)) u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (ras_start),
        .clear_o (rc_clear)
    );

    edo_row_track #(.ROW_W(ROW_W)) u_row (
        .clk       (clk),
        .rst_n     (rst_n),
        .open_i    (state_q == ST_ACT),
        .close_i   (state_q == ST_PRE),
        .row_i     (lat_row_q),
        .cmp_row_i (req_addr[ADDR_W-1:COL_W]),
        .hit_o     (row_hit)
    );

    // Ready depends only on state, never on req_valid.
    always_comb begin
        unique case (state_q)
            ST_IDLE:          req_ready = !ref_go && !have_req_q && rc_clear;
            ST_CASH, ST_OPEN: req_ready = !ref_go;
            default:          req_ready = 1'b0;
        endcase
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PWRUP: if (wdone) state_d = ST_IDLE;
            ST_IDLE: begin
                if (ref_go && rc_clear)          state_d = ST_RCAS;
                else if (have_req_q && rc_clear) state_d = ST_ACT;
                else if (accept)                 state_d = ST_ACT;
            end
            ST_ACT:  if (wdone) state_d = ST_COL;
            ST_COL:  state_d = ST_CAS;
            ST_CAS:  if (wdone) state_d = ST_CASH;
            ST_CASH, ST_OPEN: begin
                if (ref_go)                            state_d = ST_PRE;
                else if (accept)                       state_d = row_hit ? ST_COL : ST_PRE;
                else if (state_q == ST_CASH)           state_d = ST_OPEN;
                else if (wdone)                        state_d = ST_PRE;
            end
            ST_PRE:  if (wdone) state_d = ST_IDLE;
            ST_RCAS: state_d = ST_RRAS;
            ST_RRAS: if (wdone) state_d = ST_RPRE;
            ST_RPRE: if (wdone) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and its dwell counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PWRUP;
            wcnt_q  <= CNT_W'(PWRUP_CYC - 1);
        end else begin
            state_q <= state_d;
            if (state_d != state_q) wcnt_q <= dur(state_d);
            else if (!wdone)        wcnt_q <= wcnt_q - 1'b1;
        end
    end

    // Request latch, init refresh count and read capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_left_q <= INIT_W'(INIT_REF);
            lat_row_q   <= '0;
            lat_col_q   <= '0;
            lat_we_q    <= 1'b0;
            lat_wd_q    <= '0;
            have_req_q  <= 1'b0;
            rd_valid_q  <= 1'b0;
            rd_data_q   <= '0;
        end else begin
            if ((state_q == ST_RCAS) && (init_left_q != '0))
                init_left_q <= init_left_q - 1'b1;
            if (accept) begin
                lat_row_q <= req_addr[ADDR_W-1:COL_W];
                lat_col_q <= req_addr[COL_W-1:0];
                lat_we_q  <= req_we;
                lat_wd_q  <= req_wdata;
            end
            if (state_d == ST_COL) have_req_q <= 1'b0;
            else if (accept)       have_req_q <= 1'b1;
            rd_valid_q <= (state_q == ST_CAS) && (state_d == ST_CASH) && !lat_we_q;
            if ((state_q == ST_CAS) && (state_d == ST_CASH) && !lat_we_q)
                rd_data_q <= dram_dq_in;
        end
    end

    // Memory-side outputs decoded from the state.
    always_comb begin
        dram_ras_n  = 1'b1;
        dram_cas_n  = 1'b1;
        dram_we_n   = 1'b1;
        dram_oe_n   = 1'b1;
        dram_dq_oe  = 1'b0;
        dram_addr   = '0;
        dram_dq_out = lat_wd_q;
        unique case (state_q)
            ST_ACT: begin
                dram_ras_n = 1'b0;
                dram_addr  = BUS_W'(lat_row_q);
            end
            ST_COL, ST_CAS: begin
                dram_ras_n = 1'b0;
                dram_cas_n = (state_q == ST_COL);
                dram_addr  = BUS_W'(lat_col_q);
                dram_we_n  = !lat_we_q;
                dram_oe_n  = lat_we_q;
                dram_dq_oe = lat_we_q;
            end
            ST_CASH, ST_OPEN: dram_ras_n = 1'b0;
            ST_RCAS: dram_cas_n = 1'b0;
            ST_RRAS: begin
                dram_cas_n = 1'b0;
                dram_ras_n = 1'b0;
            end
            default: ;
        endcase
    end

    assign rd_valid = rd_valid_q;
    assign rd_data  = rd_data_q;
endmodule

// File: rtl/edo_dram_ctrl_chk.sv
module edo_dram_ctrl_chk #(
    parameter int T_RC  = 9,
    parameter int T_RP  = 3,
    parameter int BUS_W = 12,
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             oe_n,
    input logic             dq_oe,
    input logic [BUS_W-1:0] addr,
    input logic             rd_valid,
    input logic             req_ready,
    input logic             ref_pend
);
    localparam int GW = $clog2(T_RC + 1);
    localparam int PW = $clog2(T_RP + 1);

    logic          ras_prev;
    logic [GW-1:0] gap_q;
    logic [PW-1:0] pre_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_prev <= 1'b1;
            gap_q    <= GW'(T_RC);
            pre_q    <= PW'(T_RP);
        end else begin
            ras_prev <= ras_n;
            if (ras_prev && !ras_n)       gap_q <= GW'(1);
            else if (gap_q < GW'(T_RC))   gap_q <= gap_q + 1'b1;
            if (!ras_n)                   pre_q <= '0;
            else if (pre_q < PW'(T_RP))   pre_q <= pre_q + 1'b1;
        end
    end

    // R6
    p_row_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> gap_q >= GW'(T_RC));
    // R5
    p_precharge_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> pre_q >= PW'(T_RP));
    // R9
    p_cbr_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !cas_n) |-> !$past(cas_n));
    // R8
    p_write_no_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (oe_n && dq_oe));
    // R8
    p_write_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !we_n) |-> ($past(!we_n) && $past(dq_oe)));
    // R7
    p_read_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (cas_n && !ras_n && !$past(cas_n)));
    // R10
    p_ref_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pend |-> !req_ready);
    // R3
    p_col_ext_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !ras_n) |-> ((addr >> COL_W) == '0));
endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(
    .T_RC  (T_RC),
    .T_RP  (T_RP),
    .BUS_W (BUS_W),
    .COL_W (COL_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ras_n     (dram_ras_n),
    .cas_n     (dram_cas_n),
    .we_n      (dram_we_n),
    .oe_n      (dram_oe_n),
    .dq_oe     (dram_dq_oe),
    .addr      (dram_addr),
    .rd_valid  (rd_valid),
    .req_ready (req_ready),
    .ref_pend  (ref_pend)
);

// File: tb/edo_dram_ctrl_tb_top.sv
module edo_dram_ctrl_tb_top;
    localparam int PWRUP = 40;
    localparam int REFI  = 400;
    localparam int IDLEC = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [21:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [3:0]  req_wdata = '0;
    logic        rd_valid;
    logic [3:0]  rd_data;
    logic [11:0] dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [3:0]  dram_dq_in = '0;
    logic [3:0]  dram_dq_out;

    always #10 clk = ~clk;

    edo_dram_ctrl #(
        .PWRUP_CYC (PWRUP),
        .REFI_CYC  (REFI),
        .IDLE_CLOSE(IDLEC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
        .dram_dq_in(dram_dq_in), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural DRAM model (negedge) ----------------
    bit [3:0] mem [int];
    bit       prev_ras = 1'b1, prev_cas = 1'b1, prev_we = 1'b1, prev_dqoe = 1'b0;
    int       ras_cnt = 0, cas_cnt = 0, gap = 0, hi_cnt = 0;
    int       min_gap = 1000000, min_pre = 1000000;
    bit       seen_fall = 1'b0;
    int       act_cnt = 0, cbr_cnt = 0, wr_err = 0;
    int       cyc = 0, first_fall = -1;
    logic [11:0] cur_row = '0;
    logic [9:0]  cur_col = '0;
    logic [3:0]  rd_word = '0;

    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            gap++;
            if (prev_ras && !dram_ras_n) begin
                if (first_fall < 0) first_fall = cyc;
                if (seen_fall && gap < min_gap) min_gap = gap;
                if (hi_cnt < min_pre) min_pre = hi_cnt;
                seen_fall = 1'b1;
                gap = 0;
                if (!dram_cas_n) cbr_cnt++;
                else begin
                    act_cnt++;
                    cur_row = dram_addr;
                end
            end
            if (dram_ras_n) hi_cnt++; else hi_cnt = 0;
            if (!dram_ras_n) ras_cnt++; else ras_cnt = 0;
            if (prev_cas && !dram_cas_n && !dram_ras_n) begin
                cur_col = dram_addr[9:0];
                cas_cnt = 0;
                if (!dram_we_n) begin
                    if (!(dram_oe_n && dram_dq_oe && !prev_we && prev_dqoe)) wr_err++;
                    mem[{cur_row, cur_col}] = dram_dq_out;
                end else begin
                    rd_word = mem.exists({cur_row, cur_col}) ? mem[{cur_row, cur_col}] : 4'h0;
                end
            end
            if (!dram_cas_n) cas_cnt++;
            dram_dq_in = (!dram_oe_n && ras_cnt >= 5 && cas_cnt >= 2) ? rd_word : ~rd_word;
            prev_ras  = dram_ras_n;
            prev_cas  = dram_cas_n;
            prev_we   = dram_we_n;
            prev_dqoe = dram_dq_oe;
        end
    end

    // ---------------- scoreboard ----------------
    logic [3:0] exp_q [$];
    bit   [3:0] shadow [int];
    int   rd_issued = 0, rd_seen = 0;

    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            rd_seen++;
            if (exp_q.size() == 0) chk(1'b0, "R12 unexpected rd_valid", 1, 0);
            else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R7 read data", rd_data, e);
            end
        end
    end

    // Caller is at a negedge.
    task automatic xfer(input logic [21:0] a, input bit we, input logic [3:0] d);
        req_valid = 1'b1;
        req_addr  = a;
        req_we    = we;
        req_wdata = d;
        while (!req_ready) @(negedge clk);
        if (we) shadow[a] = d;
        else begin
            exp_q.push_back(shadow.exists(a) ? shadow[a] : 4'h0);
            rd_issued++;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        while (exp_q.size() != 0 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(exp_q.size() == 0, "R12 reads returned", exp_q.size(), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        int a0, c0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes high in reset", 0, 1);
        chk(!dram_dq_oe && !req_ready && !rd_valid, "R1 drive/ready low in reset", 1, 0);
        rst_n = 1'b1;

        while (!req_ready) @(negedge clk);
        chk(first_fall >= PWRUP, "R1 power-up delay", first_fall, PWRUP);
        chk(cbr_cnt == 8, "R2 init refresh count", cbr_cnt, 8);
        chk(act_cnt == 0, "R2 no activation during init", act_cnt, 0);

        // R3 / R4: page hits
        a0 = act_cnt;
        xfer({12'h5A3, 10'h011}, 1'b1, 4'h9);
        repeat (8) @(negedge clk);
        chk(cur_row == 12'h5A3, "R3 row on bus", cur_row, 12'h5A3);
        chk(cur_col == 10'h011, "R3 column on bus", cur_col, 10'h011);
        xfer({12'h5A3, 10'h012}, 1'b1, 4'h6);
        xfer({12'h5A3, 10'h011}, 1'b0, 4'h0);
        xfer({12'h5A3, 10'h012}, 1'b0, 4'h0);
        drain();
        chk(act_cnt == a0 + 1, "R4 page hits without new row", act_cnt, a0 + 1);

        // R11: idle close
        repeat (IDLEC + 8) @(negedge clk);
        chk(dram_ras_n == 1'b1, "R11 idle row closed", dram_ras_n, 1);

        // R5: page misses
        a0 = act_cnt;
        xfer({12'h0F0, 10'h3FF}, 1'b1, 4'hC);
        xfer({12'h5A3, 10'h011}, 1'b0, 4'h0);
        xfer({12'h0F0, 10'h3FF}, 1'b0, 4'h0);
        drain();
        chk(act_cnt == a0 + 3, "R5 miss reopens row", act_cnt, a0 + 3);

        // R9: periodic refresh while idle
        c0 = cbr_cnt;
        repeat (1600) @(negedge clk);
        chk(cbr_cnt - c0 >= 3 && cbr_cnt - c0 <= 5, "R9 refresh while idle", cbr_cnt - c0, 4);

        // R10: refresh under a stream of page hits
        for (int i = 0; i < 16; i++) xfer({12'h222, 10'(i)}, 1'b1, 4'(i ^ 5));
        c0 = cbr_cnt;
        for (int i = 0; i < 150; i++) xfer({12'h222, 10'(i % 16)}, 1'b0, 4'h0);
        drain();
        chk(cbr_cnt > c0, "R10 refresh during hit stream", cbr_cnt - c0, 1);

        // R3: address extremes
        xfer(22'h3FFFFF, 1'b1, 4'hA);
        xfer(22'h000000, 1'b1, 4'h5);
        xfer(22'h3FFFFF, 1'b0, 4'h0);
        xfer(22'h000000, 1'b0, 4'h0);
        drain();
        chk(cur_row == 12'h000 && cur_col == 10'h000, "R3 zero address", {cur_row, cur_col}, 0);

        repeat (10) @(negedge clk);
        chk(min_gap >= 9, "R6 row cycle gap", min_gap, 9);
        chk(min_pre >= 3, "R5 precharge width", min_pre, 3);
        chk(wr_err == 0, "R8 write control timing", wr_err, 0);
        chk(rd_seen == rd_issued, "R12 one pulse per read", rd_seen, rd_issued);
        finish_run();
    end
endmodule